// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor: a file of eight general registers, a function unit that adds, subtracts, masks and shifts, and two steering muxes, all driven by one packed 16-bit control word per clock. Whatever sequencer sits above it presents a word, the block reads its two operands, computes a result and, if told to, stores either that result or an external input word into the chosen destination at the next rising edge.

Operand bus A is also brought out as an address output, and operand bus B as a data output, so that a memory beside the block can be addressed and written with register contents. Four status flags (overflow, carry, negative, zero) describe the function unit result of the word currently applied. Exactly one microoperation is done per cycle.

Top module: `cw_datapath`

## Requirements
- R1: The control word is split by bit position: [15:13] destination register, [12:10] bus A source register, [9:7] bus B source register, [6] B-mux select, [5:2] function code, [1] write-back source select, [0] write enable.
- R2: While `rst_n` is low at a rising edge all eight registers become zero; reset takes priority over a write in that cycle.
- R3: With bit 0 set the destination register takes the write-back value at the rising edge; with bit 0 clear no register changes.
- R4: `addr_out` shows the register named by bits [12:10] combinationally in the same cycle.
- R5: Bit 6 clear puts the register named by bits [9:7] on bus B; bit 6 set puts `const_in` there; `data_out` always shows bus B.
- R6: Bit 1 clear writes back the function unit result; bit 1 set writes back `data_in`.
- R7: Function codes with bit 3 clear are arithmetic: the result is A + Y + c, where c is code bit 0 and Y is 0, B, the inverse of B or all ones for code bits [2:1] = 00, 01, 10, 11 (so 0101 gives A-B and 0110 gives A-1).
- R8: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R9: Codes 1101 and 1110 give B shifted right or left by one with zero fill; codes 1100 and 1111 pass B unchanged.
- R10: `flag_n` is the top bit of the function unit result and `flag_z` is set exactly when that result is zero, both for the word applied now and independent of the write-back select.
- R11: For arithmetic codes `flag_c` is the carry out of the W-bit sum and `flag_v` is set when A and Y share a sign the sum does not; for all other codes both are zero.
- R12: A register that is both a source and the destination reads its old value during the writing cycle; the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| ctrl_word | input | 16 | Microoperation control word for this cycle |
| const_in | input | W | Constant operand selectable onto bus B |
| data_in | input | W | External word selectable for write-back |
| addr_out | output | W | Bus A value |
| data_out | output | W | Bus B value |
| flag_v | output | 1 | Signed overflow of the arithmetic result |
| flag_c | output | 1 | Carry out of the arithmetic result |
| flag_n | output | 1 | Top bit of the function unit result |
| flag_z | output | 1 | Function unit result is zero |

## Verification
The read of a register and the write of that same register fall in the same cycle whenever a word names one register as both source and destination. The bench issues such words back to back, for instance incrementing a register onto itself, and expects bus A to show the old value during the writing cycle and the incremented value in the following one. A reset cycle carrying a write-enabled word is also applied, and the target register is judged by reading it back as zero.

// File: rtl/cw_datapath_pkg.sv
// Package: shared layout of the control word and function codes.
// Assumes a fixed 16-bit word with 3-bit register addresses.
package cw_datapath_pkg;

    localparam int CW_BITS   = 16;
    localparam int RADDR_W   = 3;
    localparam int NUM_REGS  = 1 << RADDR_W;
    localparam int FCODE_W   = 4;

    // Field layout, most significant field first; positions are behaviour.
    typedef struct packed {
        logic [RADDR_W-1:0] dst;
        logic [RADDR_W-1:0] src_a;
        logic [RADDR_W-1:0] src_b;
        logic               b_const;
        logic [FCODE_W-1:0] fcode;
        logic               d_ext;
        logic               wr_en;
    } ctrl_t;

    // Adder operand modes (code bits [2:1] when bit 3 is clear)
    localparam logic [1:0] YSEL_ZERO = 2'b00;
    localparam logic [1:0] YSEL_B    = 2'b01;
    localparam logic [1:0] YSEL_NOTB = 2'b10;
    localparam logic [1:0] YSEL_ONES = 2'b11;

    // Bitwise / shift operations (code bits [1:0] when bit 3 is set)
    localparam logic [1:0] BOP_AND   = 2'b00;
    localparam logic [1:0] BOP_OR    = 2'b01;
    localparam logic [1:0] BOP_XOR   = 2'b10;
    localparam logic [1:0] BOP_NOTA  = 2'b11;
    localparam logic [1:0] SOP_SHR   = 2'b01;
    localparam logic [1:0] SOP_SHL   = 2'b10;

endpackage

// File: rtl/cw_regfile.sv
// Module: register file with one write port and two combinational read ports.
// Assumes synchronous active-low reset clearing every entry; reads return the
// value held before the current edge, so read-before-write is natural.
module cw_regfile #(
    parameter int W      = 16,
    parameter int AW     = 3,
    localparam int NREGS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [W-1:0]  rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_b_data
);

    logic [W-1:0]     entry [NREGS];
    logic [NREGS-1:0] load_sel;

    // Decode the write address into one load strobe per entry
    always_comb begin
        load_sel = '0;
        if (wr_en) begin
            load_sel[wr_addr] = 1'b1;
        end
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        // Hold, clear on reset, or load one entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[i] <= '0;
            end else if (load_sel[i]) begin
                entry[i] <= wr_data;
            end
        end
    end

    // Combinational read ports
    always_comb begin
        rd_a_data = entry[rd_a_addr];
        rd_b_data = entry[rd_b_addr];
    end

endmodule

// File: rtl/cw_arith.sv
// Module: arithmetic section, A + Y + carry-in with Y chosen from B by a mode.
// Assumes W >= 2; reports carry out and two's-complement overflow.
module cw_arith
    import cw_datapath_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   y_mode,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] y_val;
    logic         carry_into_msb;

    // Build the adder's second operand from B
    always_comb begin
        unique case (y_mode)
            YSEL_ZERO: y_val = '0;
            YSEL_B:    y_val = op_b;
            YSEL_NOTB: y_val = ~op_b;
            default:   y_val = '1;
        endcase
    end

    // Full-width add with carry out
    always_comb begin
        {cout, sum} = {1'b0, op_a} + {1'b0, y_val} + {{W{1'b0}}, cin};
    end

    // Overflow from the carry into and out of the sign bit
    always_comb begin
        carry_into_msb = op_a[W-1] ^ y_val[W-1] ^ sum[W-1];
        ovf            = carry_into_msb ^ cout;
    end

endmodule

// File: rtl/cw_bitops.sv
// Module: bitwise logic and single-step shifter on the function unit operands.
// Assumes zero fill on both shift directions; B passes through otherwise.
module cw_bitops
    import cw_datapath_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         shift_grp,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result
);

    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;

    // Bitwise operations on A and B
    always_comb begin
        unique case (op_sel)
            BOP_AND: logic_res = op_a & op_b;
            BOP_OR:  logic_res = op_a | op_b;
            BOP_XOR: logic_res = op_a ^ op_b;
            default: logic_res = ~op_a;
        endcase
    end

    // Shift or pass operand B
    always_comb begin
        unique case (op_sel)
            SOP_SHR: shift_res = {1'b0, op_b[W-1:1]};
            SOP_SHL: shift_res = {op_b[W-2:0], 1'b0};
            default: shift_res = op_b;
        endcase
    end

    // Pick the group named by the code
    always_comb begin
        result = shift_grp ? shift_res : logic_res;
    end

endmodule

// File: rtl/cw_datapath.sv
// Module: control-word driven datapath top. Applies one microoperation per
// clock: reads two registers, forms bus B, runs the function unit, and writes
// back the result or data_in. Assumes the control word is stable each cycle.
module cw_datapath
    import cw_datapath_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW_BITS-1:0] ctrl_word,
    input  logic [W-1:0]       const_in,
    input  logic [W-1:0]       data_in,
    output logic [W-1:0]       addr_out,
    output logic [W-1:0]       data_out,
    output logic               flag_v,
    output logic               flag_c,
    output logic               flag_n,
    output logic               flag_z
);

    ctrl_t        cw;
    logic [W-1:0] bus_a;
    logic [W-1:0] reg_b;
    logic [W-1:0] bus_b;
    logic [W-1:0] arith_res;
    logic [W-1:0] bit_res;
    logic [W-1:0] func_res;
    logic [W-1:0] bus_d;
    logic         arith_cout;
    logic         arith_ovf;
    logic         is_bitop;

    // Split the word into its named fields
    always_comb begin
        cw       = ctrl_t'(ctrl_word);
        is_bitop = cw.fcode[3];
    end

    cw_regfile #(
        .W  (W),
        .AW (RADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw.wr_en),
        .wr_addr   (cw.dst),
        .wr_data   (bus_d),
        .rd_a_addr (cw.src_a),
        .rd_a_data (bus_a),
        .rd_b_addr (cw.src_b),
        .rd_b_data (reg_b)
    );

    // Bus B source: register or external constant
    always_comb begin
        bus_b = cw.b_const ? const_in : reg_b;
    end

    cw_arith #(.W(W)) u_arith (
        .op_a   (bus_a),
        .op_b   (bus_b),
        .y_mode (cw.fcode[2:1]),
        .cin    (cw.fcode[0]),
        .sum    (arith_res),
        .cout   (arith_cout),
        .ovf    (arith_ovf)
    );

    cw_bitops #(.W(W)) u_bitops (
        .op_a      (bus_a),
        .op_b      (bus_b),
        .shift_grp (cw.fcode[2]),
        .op_sel    (cw.fcode[1:0]),
        .result    (bit_res)
    );

    // Function unit output and status flags
    always_comb begin
        func_res = is_bitop ? bit_res : arith_res;
        flag_c   = is_bitop ? 1'b0 : arith_cout;
        flag_v   = is_bitop ? 1'b0 : arith_ovf;
        flag_n   = func_res[W-1];
        flag_z   = (func_res == '0);
    end

    // Write-back source and external buses
    always_comb begin
        bus_d    = cw.d_ext ? data_in : func_res;
        addr_out = bus_a;
        data_out = bus_b;
    end

endmodule

// File: rtl/cw_datapath_chk.sv
// Module: property checker bound to the datapath top.
// Assumes it observes the top's ports plus the write-back bus.
module cw_datapath_chk
    import cw_datapath_pkg::*;
#(
    parameter int W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW_BITS-1:0] ctrl_word,
    input logic [W-1:0]       const_in,
    input logic [W-1:0]       addr_out,
    input logic [W-1:0]       data_out,
    input logic [W-1:0]       bus_d,
    input logic               flag_v,
    input logic               flag_c,
    input logic               flag_n,
    input logic               flag_z
);

    ctrl_t f;
    always_comb f = ctrl_t'(ctrl_word);

    AST_CONST_ON_BUS_B: assert property (@(posedge clk) disable iff (!rst_n)
        f.b_const |-> (data_out == const_in)); // R5

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(f.wr_en) && (f.src_a == $past(f.dst)))
            |-> (addr_out == $past(bus_d))); // R3

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(f.wr_en) && (f.src_a == $past(f.src_a)))
            |-> (addr_out == $past(addr_out))); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (addr_out == '0)); // R2

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n); // R10

    AST_BITOP_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        f.fcode[3] |-> (!flag_c && !flag_v)); // R11

endmodule

bind cw_datapath cw_datapath_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .const_in  (const_in),
    .addr_out  (addr_out),
    .data_out  (data_out),
    .bus_d     (bus_d),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/cw_datapath_bench.sv
`timescale 1ns/1ps
module cw_datapath_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  ctrl_word = '0;
    logic [W-1:0] const_in = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] addr_out, data_out;
    logic         flag_v, flag_c, flag_n, flag_z;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [3:0]   f;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] model [8];

    always #5 clk = ~clk;

    cw_datapath #(.W(W)) u_cw_datapath (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .const_in(const_in), .data_in(data_in),
        .addr_out(addr_out), .data_out(data_out),
        .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    function automatic logic [15:0] cwf(input logic [2:0] da, input logic [2:0] aa,
                                        input logic [2:0] ba, input logic mb,
                                        input logic [3:0] fs, input logic md,
                                        input logic rw);
        return {da, aa, ba, mb, fs, md, rw};
    endfunction

    // Driver: apply one word, predict outputs from the requirements, queue them
    task automatic drive(input logic [15:0] cw, input logic [W-1:0] k,
                         input logic [W-1:0] din, input string tag);
        exp_t         e;
        logic [W-1:0] av, bv, fv, dv, y;
        logic [W:0]   s;
        logic         c, v;
        @(negedge clk);
        ctrl_word = cw; const_in = k; data_in = din;
        av = model[cw[12:10]];
        bv = cw[6] ? k : model[cw[9:7]];
        c = 1'b0; v = 1'b0;
        if (!cw[5]) begin
            case (cw[4:3])
                2'b00:   y = '0;
                2'b01:   y = bv;
                2'b10:   y = ~bv;
                default: y = '1;
            endcase
            s  = {1'b0, av} + {1'b0, y} + {{W{1'b0}}, cw[2]};
            fv = s[W-1:0];
            c  = s[W];
            v  = (av[W-1] == y[W-1]) && (fv[W-1] != av[W-1]);
        end else if (!cw[4]) begin
            case (cw[3:2])
                2'b00:   fv = av & bv;
                2'b01:   fv = av | bv;
                2'b10:   fv = av ^ bv;
                default: fv = ~av;
            endcase
        end else begin
            case (cw[3:2])
                2'b01:   fv = bv >> 1;
                2'b10:   fv = bv << 1;
                default: fv = bv;
            endcase
        end
        dv    = cw[1] ? din : fv;
        e.a   = av;
        e.b   = bv;
        e.f   = {v, c, fv[W-1], (fv == '0)};
        e.tag = tag;
        sb.push_back(e);
        if (cw[0]) model[cw[15:13]] = dv;
    endtask

    // Monitor: compare each queued prediction mid-cycle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() != 0) begin
                e = sb.pop_front();
                n_vec++;
                if ({addr_out, data_out, flag_v, flag_c, flag_n, flag_z} !==
                    {e.a, e.b, e.f}) begin
                    n_fail++;
                    $display("FAIL %s: addr=%h data=%h vcnz=%b expected addr=%h data=%h vcnz=%b",
                             e.tag, addr_out, data_out,
                             {flag_v, flag_c, flag_n, flag_z}, e.a, e.b, e.f);
                end
            end
        end
    end

    task automatic mid_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl_word = cwf(3'd7, 3'd0, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1);
        data_in = 16'hAAAA;
        @(negedge clk);
        rst_n = 1'b1;
        ctrl_word = '0;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every register reads zero after reset
        for (int i = 0; i < 8; i++)
            drive(cwf(3'd0, 3'(i), 3'(7 - i), 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R2");

        // R6: load registers from data_in
        drive(cwf(3'd1, 3'd0, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h1234, "R6");
        drive(cwf(3'd2, 3'd1, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h00F0, "R6");
        drive(cwf(3'd3, 3'd2, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h000F, "R6");
        drive(cwf(3'd4, 3'd3, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h8000, "R6");
        drive(cwf(3'd5, 3'd4, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h7FFF, "R6");
        drive(cwf(3'd6, 3'd5, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'hFFFF, "R6");
        drive(cwf(3'd7, 3'd6, 3'd0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 16'h5555, "R6");
        drive(cwf(3'd0, 3'd7, 3'd1, 1'b0, 4'b0010, 1'b0, 1'b0), '0, '0, "R4");

        // R1: packed word 001 010 011 0 0101 0 1 -> R1 = R2 - R3
        drive(16'b001_010_011_0_0101_0_1, '0, '0, "R1");
        drive(cwf(3'd0, 3'd1, 3'd2, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R1");

        // R7: arithmetic codes
        drive(cwf(3'd0, 3'd2, 3'd3, 1'b0, 4'b0010, 1'b0, 1'b0), '0, '0, "R7");
        drive(cwf(3'd0, 3'd2, 3'd3, 1'b0, 4'b0011, 1'b0, 1'b0), '0, '0, "R7");
        drive(cwf(3'd0, 3'd2, 3'd3, 1'b0, 4'b0100, 1'b0, 1'b0), '0, '0, "R7");
        drive(cwf(3'd0, 3'd3, 3'd2, 1'b0, 4'b0101, 1'b0, 1'b0), '0, '0, "R7");
        drive(cwf(3'd0, 3'd2, 3'd0, 1'b0, 4'b0111, 1'b0, 1'b0), '0, '0, "R7");
        drive(cwf(3'd0, 3'd0, 3'd0, 1'b0, 4'b0110, 1'b0, 1'b0), '0, '0, "R7");

        // R11: signed overflow and carry
        drive(cwf(3'd0, 3'd5, 3'd0, 1'b0, 4'b0001, 1'b0, 1'b0), '0, '0, "R11");
        drive(cwf(3'd0, 3'd4, 3'd5, 1'b0, 4'b0101, 1'b0, 1'b0), '0, '0, "R11");
        drive(cwf(3'd0, 3'd6, 3'd6, 1'b0, 4'b0010, 1'b0, 1'b0), '0, '0, "R11");

        // R3: word 010 000 011 0 0110 0 0 computes but writes nothing
        drive(16'b010_000_011_0_0110_0_0, '0, 16'hDEAD, "R3");
        drive(cwf(3'd0, 3'd2, 3'd2, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R3");

        // R8: bitwise codes
        drive(cwf(3'd0, 3'd7, 3'd1, 1'b0, 4'b1000, 1'b0, 1'b0), '0, '0, "R8");
        drive(cwf(3'd0, 3'd7, 3'd1, 1'b0, 4'b1001, 1'b0, 1'b0), '0, '0, "R8");
        drive(cwf(3'd0, 3'd7, 3'd6, 1'b0, 4'b1010, 1'b0, 1'b0), '0, '0, "R8");
        drive(cwf(3'd0, 3'd6, 3'd0, 1'b0, 4'b1011, 1'b0, 1'b0), '0, '0, "R8");

        // R9: shifts and pass of B, incl. shifting out the last set bit
        drive(cwf(3'd0, 3'd0, 3'd4, 1'b0, 4'b1101, 1'b0, 1'b0), '0, '0, "R9");
        drive(cwf(3'd0, 3'd0, 3'd4, 1'b0, 4'b1110, 1'b0, 1'b0), '0, '0, "R9");
        drive(cwf(3'd0, 3'd0, 3'd7, 1'b0, 4'b1100, 1'b0, 1'b0), '0, '0, "R9");
        drive(cwf(3'd0, 3'd0, 3'd7, 1'b0, 4'b1111, 1'b0, 1'b0), '0, '0, "R9");

        // R5: constant on bus B, stored via shift-left write-back
        drive(cwf(3'd0, 3'd1, 3'd1, 1'b1, 4'b1100, 1'b0, 1'b0), 16'h0C3C, '0, "R5");
        drive(cwf(3'd4, 3'd1, 3'd1, 1'b1, 4'b1110, 1'b0, 1'b1), 16'h4001, '0, "R5");
        drive(cwf(3'd0, 3'd4, 3'd4, 1'b0, 4'b0000, 1'b0, 1'b0), 16'hFFFF, '0, "R5");

        // R10: flags follow F, not the data_in write-back
        drive(cwf(3'd0, 3'd0, 3'd6, 1'b0, 4'b1100, 1'b1, 1'b1), '0, 16'h0000, "R10");
        drive(cwf(3'd0, 3'd0, 3'd6, 1'b0, 4'b1000, 1'b1, 1'b0), '0, '0, "R10");

        // R12: increment a register onto itself twice back to back
        drive(cwf(3'd3, 3'd3, 3'd3, 1'b0, 4'b0001, 1'b0, 1'b1), '0, '0, "R12");
        drive(cwf(3'd3, 3'd3, 3'd3, 1'b0, 4'b0001, 1'b0, 1'b1), '0, '0, "R12");
        drive(cwf(3'd0, 3'd3, 3'd3, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R12");

        // R2: reset wins over a write in the same cycle
        mid_reset();
        drive(cwf(3'd0, 3'd7, 3'd1, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R2");
        drive(cwf(3'd0, 3'd4, 3'd6, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0, "R2");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(1_000_000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule